// File: doc/BRIEF.md
# DMA Slave Transfer Counter Controller

This block controls a peripheral's side of a DMA transfer in which an external DMA master drives the timing. Software writes a configuration and a transfer length through a byte-wide register port, then issues a read or write command. While the transfer runs, the controller counts data items. Each item is marked by one clock cycle in which the selected strobe input is high. The strobe can be the acknowledge line, the read strobe or the write strobe.

The controller has two modes. In counting mode it finishes when the programmed count runs out, then sets a completion flag and can raise an interrupt. In end-only mode it ignores the count and waits for the master's end-of-transfer input. In either mode that input stops a running transfer at once. The remaining count can then still be read back. The data path itself is not part of this block: strobes stand in for data beats.

The 32-bit length is written one byte at a time, lowest byte first. It takes effect only on the write of the top byte, so a half-written value never reaches the counter.

Top module: `dma_xfer_ctl`

## Requirements
- R1: After reset, `busy`, `xfer_dir` and `irq` are 0, every status bit reads 0 and the counter reads 0.
- R2: The count bytes sit at addresses 34h (least significant) to 37h (most significant). Writes to 34h–36h only stage a byte and leave the readable counter unchanged. A write to 37h loads all four bytes into the counter when no transfer is running; while busy, that load is dropped. Reading 34h–37h returns the live counter bytes.
- R3: Writing 00h to the command address 30h starts a read transfer (`xfer_dir`=0) and writing 01h starts a write transfer (`xfer_dir`=1), when idle. Any other value written there has no effect.
- R4: Configuration register 38h bits [1:0] select the counted strobe: 0 acknowledge, 1 read strobe, 2 write strobe, 3 none. Only the selected input counts, one item per cycle in which it is high. Bits [1:0] and bit 2 are captured when a command starts; later writes do not affect the running transfer.
- R5: In counting mode (38h bit 2 = 0), each counted item lowers the counter by one. When the counter reaches zero, `busy` falls and status bit 0 (done) is set. A command issued with a zero count sets done at once, without `busy` rising.
- R6: In end-only mode (38h bit 2 = 1), strobes change neither the counter nor `busy`.
- R7: `eot_in` high while busy ends the transfer at that edge and sets status bit 1. The counter keeps its remaining value. A strobe in the same cycle is not counted. `eot_in` while idle has no effect.
- R8: Strobes arriving while no transfer is running change nothing.
- R9: A valid command while busy leaves the transfer and `xfer_dir` unchanged and sets status bit 2 (error).
- R10: The status register at 3Ch is write-1-to-clear on bits 0–2. Writing 0 to a bit leaves it unchanged. Bit 3 reads `busy`.
- R11: `irq` is high exactly when status bit 0 is set and bit 0 of the enable register 3Dh is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| stb_ack | input | 1 | Acknowledge strobe from the DMA master |
| stb_rd | input | 1 | Read strobe from the DMA master |
| stb_wr | input | 1 | Write strobe from the DMA master |
| eot_in | input | 1 | End-of-transfer from the DMA master |
| busy | output | 1 | Transfer in progress |
| xfer_dir | output | 1 | Direction of the last started transfer (1 = write) |
| irq | output | 1 | Completion interrupt |

## Verification
Random trials drive all three strobe lines together with independent random patterns, so a wrong strobe selection shows up as a wrong decrement count. Each trial uses a random length, selection, mode and end-of-transfer timing, so counting-mode completion, end-only waits and early termination are told apart by the final count and by which status bit is set. Directed cases cover:
- partial count writes and a top-byte write while busy;
- a zero-length command;
- an end-of-transfer that coincides with a strobe;
- a configuration rewrite during a transfer;
- commands issued while busy.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    SRC_ACK  = 2'd0,
    SRC_RD   = 2'd1,
    SRC_WR   = 2'd2,
    SRC_NONE = 2'd3
  } strobe_src_e;

  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_EOT  = 1;
  localparam int unsigned ST_ERR  = 2;
  localparam int unsigned ST_BITS = 3;

  function automatic logic pick_strobe(input logic [1:0] sel, input logic a,
                                       input logic r, input logic w);
    case (strobe_src_e'(sel))
      SRC_ACK: return a;
      SRC_RD:  return r;
      SRC_WR:  return w;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dma_cnt_stage.sv
module dma_cnt_stage #(
  parameter int unsigned CNT_W = 32,
  localparam int unsigned NB = CNT_W / 8,
  localparam int unsigned IW = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IW-1:0]    idx,
  input  logic [7:0]       wdata,
  output logic             commit,
  output logic [CNT_W-1:0] value
);
  logic [7:0] stage_q [NB-1];

  generate
    for (genvar i = 0; i < NB - 1; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else if (wr && idx == IW'(i)) stage_q[i] <= wdata;
      end
      assign value[i*8 +: 8] = stage_q[i];
    end
  endgenerate

  assign value[CNT_W-1 -: 8] = wdata;
  assign commit = wr && idx == IW'(NB - 1);
endmodule

// File: rtl/dma_xfer_core.sv
module dma_xfer_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_dir,
  input  logic [1:0]       cfg_sel,
  input  logic             cfg_nc,
  input  logic             stb_ack,
  input  logic             stb_rd,
  input  logic             stb_wr,
  input  logic             eot,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             dir,
  output logic             nc_mode,
  output logic [CNT_W-1:0] cnt,
  output logic             evt_step,
  output logic             evt_eot,
  output logic             evt_done
);
  logic             busy_q, dir_q, nc_q;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit, last, zero_start;

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  always_comb begin
    hit        = dma_xfer_pkg::pick_strobe(sel_q, stb_ack, stb_rd, stb_wr);
    last       = (cnt_q == CNT_W'(1));
    zero_start = start && !cfg_nc && (cnt_q == '0);
    evt_eot    = busy_q && eot;
    evt_step   = busy_q && !eot && !nc_q && hit;
    evt_done   = (evt_step && last) || zero_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      nc_q   <= 1'b0;
      sel_q  <= 2'd0;
    end else if (start) begin
      busy_q <= !zero_start;
      dir_q  <= start_dir;
      nc_q   <= cfg_nc;
      sel_q  <= cfg_sel;
    end else if (evt_eot || (evt_step && last)) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load_en)  cnt_q <= load_val;
    else if (evt_step) cnt_q <= count_down(cnt_q);
  end

  assign busy    = busy_q;
  assign dir     = dir_q;
  assign nc_mode = nc_q;
  assign cnt     = cnt_q;
endmodule

// File: rtl/dma_status.sv
module dma_status #(
  parameter int unsigned NBITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] set,
  input  logic             clr_wr,
  input  logic [NBITS-1:0] clr_mask,
  output logic [NBITS-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else flags <= (flags & ~(clr_wr ? clr_mask : '0)) | set;
  end
endmodule

// File: rtl/dma_xfer_ctl.sv
module dma_xfer_ctl #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  ADDR_CMD = 8'h30,
  parameter logic [7:0]  ADDR_CNT = 8'h34,
  parameter logic [7:0]  ADDR_CFG = 8'h38,
  parameter logic [7:0]  ADDR_ST  = 8'h3C,
  parameter logic [7:0]  ADDR_IEN = 8'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              stb_ack,
  input  logic              stb_rd,
  input  logic              stb_wr,
  input  logic              eot_in,
  output logic              busy,
  output logic              xfer_dir,
  output logic              irq
);
  import dma_xfer_pkg::*;
  localparam int unsigned NB = CNT_W / 8;
  localparam int unsigned IW = $clog2(NB);

  logic [2:0]       cfg_q;
  logic             ien_q;
  logic             cnt_sel, cmd_valid, evt_start, evt_cmd_bad, evt_commit;
  logic             stage_commit, evt_step, evt_eot, evt_done, nc_mode;
  logic [IW-1:0]    cnt_idx;
  logic [CNT_W-1:0] stage_val, cnt;
  logic [ST_BITS-1:0] st_flags, st_set;

  always_comb begin
    cnt_sel     = (reg_addr >= ADDR_W'(ADDR_CNT)) &&
                  (reg_addr < ADDR_W'(ADDR_CNT) + ADDR_W'(NB));
    cnt_idx     = IW'(reg_addr - ADDR_W'(ADDR_CNT));
    cmd_valid   = reg_we && reg_addr == ADDR_W'(ADDR_CMD) && reg_wdata[7:1] == '0;
    evt_start   = cmd_valid && !busy;
    evt_cmd_bad = cmd_valid && busy;
    evt_commit  = stage_commit && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ien_q <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_W'(ADDR_CFG)) cfg_q <= reg_wdata[2:0];
      if (reg_addr == ADDR_W'(ADDR_IEN)) ien_q <= reg_wdata[0];
    end
  end

  dma_cnt_stage #(.CNT_W(CNT_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr(reg_we && cnt_sel), .idx(cnt_idx),
    .wdata(reg_wdata), .commit(stage_commit), .value(stage_val)
  );

  dma_xfer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(evt_start), .start_dir(reg_wdata[0]),
    .cfg_sel(cfg_q[1:0]), .cfg_nc(cfg_q[2]), .stb_ack(stb_ack),
    .stb_rd(stb_rd), .stb_wr(stb_wr), .eot(eot_in), .load_en(evt_commit),
    .load_val(stage_val), .busy(busy), .dir(xfer_dir), .nc_mode(nc_mode),
    .cnt(cnt), .evt_step(evt_step), .evt_eot(evt_eot), .evt_done(evt_done)
  );

  always_comb begin
    st_set          = '0;
    st_set[ST_DONE] = evt_done;
    st_set[ST_EOT]  = evt_eot;
    st_set[ST_ERR]  = evt_cmd_bad;
  end

  dma_status #(.NBITS(ST_BITS)) u_status (
    .clk(clk), .rst_n(rst_n), .set(st_set),
    .clr_wr(reg_we && reg_addr == ADDR_W'(ADDR_ST)),
    .clr_mask(reg_wdata[ST_BITS-1:0]), .flags(st_flags)
  );

  assign irq = st_flags[ST_DONE] && ien_q;

  always_comb begin
    reg_rdata = '0;
    if (cnt_sel)                             reg_rdata = 8'(cnt >> (8 * cnt_idx));
    else if (reg_addr == ADDR_W'(ADDR_CFG))  reg_rdata = {5'd0, cfg_q};
    else if (reg_addr == ADDR_W'(ADDR_ST))   reg_rdata = {4'd0, busy, st_flags};
    else if (reg_addr == ADDR_W'(ADDR_IEN))  reg_rdata = {7'd0, ien_q};
  end
endmodule

// File: rtl/dma_xfer_ctl_chk.sv
module dma_xfer_ctl_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             nc_mode,
  input logic             evt_step,
  input logic             evt_eot,
  input logic             evt_done,
  input logic             evt_cmd_bad,
  input logic             evt_commit,
  input logic [2:0]       st_flags
);
  a_r5_step_dec: assert property (@(posedge clk) disable iff (!rst_n)
    evt_step |=> cnt == $past(cnt) - CNT_W'(1));
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !busy && st_flags[0]);
  a_r7_eot_end: assert property (@(posedge clk) disable iff (!rst_n)
    evt_eot |=> !busy && st_flags[1] && $stable(cnt));
  a_r9_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmd_bad |=> busy && st_flags[2]);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !evt_commit |=> $stable(cnt));
  a_r6_nocount_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && nc_mode |=> $stable(cnt));
  a_r11_irq_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st_flags[0]);
endmodule

bind dma_xfer_ctl dma_xfer_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .cnt(cnt),
  .nc_mode(nc_mode), .evt_step(evt_step), .evt_eot(evt_eot),
  .evt_done(evt_done), .evt_cmd_bad(evt_cmd_bad), .evt_commit(evt_commit),
  .st_flags(st_flags)
);

// File: tb/tb_dma_xfer_ctl.sv
module tb_dma_xfer_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic stb_ack = 1'b0, stb_rd = 1'b0, stb_wr = 1'b0, eot_in = 1'b0;
  logic busy, xfer_dir, irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dma_xfer_ctl dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rdcnt(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(8'h34 + 8'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic load(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(8'h34 + 8'(i), v[i*8 +: 8]);
  endtask

  task automatic pulse(input logic a, input logic r, input logic w, input logic e);
    stb_ack = a; stb_rd = r; stb_wr = w; eot_in = e;
    @(negedge clk);
    stb_ack = 0; stb_rd = 0; stb_wr = 0; eot_in = 0;
  endtask

  function automatic logic sel_hit(input logic [1:0] s, input logic a,
                                   input logic r, input logic w);
    return (s == 2'd0) ? a : (s == 2'd1) ? r : (s == 2'd2) ? w : 1'b0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 irq", irq, 0); chk("R1 dir", xfer_dir, 0);
    rd(8'h3C, b); chk("R1 status", b, 0);
    rdcnt(v); chk("R1 count", v, 0);
    // R2 staging then commit
    wr(8'h34, 8'hAA); wr(8'h35, 8'hBB); wr(8'h36, 8'hCC);
    rdcnt(v); chk("R2 staged only", v, 0);
    wr(8'h37, 8'h11);
    rdcnt(v); chk("R2 commit", v, 32'h11CCBBAA);
    // R8 strobes while idle
    repeat (3) pulse(1, 1, 1, 0);
    rdcnt(v); chk("R8 idle strobes", v, 32'h11CCBBAA); chk("R8 busy", busy, 0);
    // R3 invalid opcode
    wr(8'h30, 8'h02); chk("R3 bad opcode", busy, 0);
    // R4/R5 counting with read-strobe select
    load(32'd3); wr(8'h38, 8'h01); wr(8'h3D, 8'h00);
    wr(8'h30, 8'h01); chk("R3 start busy", busy, 1); chk("R3 dir write", xfer_dir, 1);
    pulse(1, 0, 1, 0); pulse(1, 0, 1, 0);
    rdcnt(v); chk("R4 unselected strobes", v, 3);
    pulse(0, 1, 0, 0);
    rdcnt(v); chk("R5 decrement", v, 2);
    load(32'd9);
    rdcnt(v); chk("R2 commit while busy dropped", v, 2);
    wr(8'h30, 8'h00);
    rd(8'h3C, b); chk("R9 error bit", b[2], 1); chk("R9 dir kept", xfer_dir, 1);
    chk("R9 still busy", busy, 1);
    pulse(0, 1, 0, 0); pulse(0, 1, 0, 0);
    chk("R5 done idle", busy, 0);
    rd(8'h3C, b); chk("R5 done bit", b[0], 1);
    rdcnt(v); chk("R5 count zero", v, 0);
    chk("R11 irq masked", irq, 0);
    wr(8'h3D, 8'h01); chk("R11 irq enabled", irq, 1);
    wr(8'h3C, 8'h02);
    rd(8'h3C, b); chk("R10 write-0 keeps", b[2:0], 3'b101);
    wr(8'h3C, 8'h07);
    rd(8'h3C, b); chk("R10 w1c", b, 0); chk("R11 irq cleared", irq, 0);
    // R5 zero-length command
    wr(8'h30, 8'h00);
    chk("R5 zero start no busy", busy, 0); chk("R3 dir read", xfer_dir, 0);
    rd(8'h3C, b); chk("R5 zero start done", b[0], 1);
    wr(8'h3C, 8'h07);
    // R7 EOT in counting mode, coinciding with a strobe
    load(32'd10); wr(8'h38, 8'h00); wr(8'h30, 8'h00);
    repeat (3) pulse(1, 0, 0, 0);
    pulse(1, 0, 0, 1);
    chk("R7 eot ends", busy, 0);
    rdcnt(v); chk("R7 remaining count", v, 7);
    rd(8'h3C, b); chk("R7 eot bit only", b, 8'h02);
    wr(8'h3C, 8'h07); pulse(0, 0, 0, 1);
    rd(8'h3C, b); chk("R7 idle eot ignored", b, 0);
    // R6 end-only mode, with a config rewrite during the transfer (R4 latch)
    load(32'd5); wr(8'h38, 8'h06); wr(8'h30, 8'h01);
    repeat (8) pulse(1, 1, 1, 0);
    chk("R6 still busy", busy, 1);
    wr(8'h38, 8'h02);
    repeat (2) pulse(0, 0, 1, 0);
    rdcnt(v); chk("R6 count held", v, 5); chk("R4 config latched", busy, 1);
    pulse(0, 0, 0, 1);
    chk("R6 eot ends", busy, 0);
    rd(8'h3C, b); chk("R6 eot bit", b, 8'h02);
    // random trials
    for (int t = 0; t < 40; t++) begin
      logic nc, ien, bm, dm, em;
      logic [1:0] sel;
      logic [31:0] cm;
      nc = ($urandom % 4) == 0; sel = 2'($urandom % 4);
      cm = 1 + ($urandom % 12); ien = 1'($urandom % 2);
      wr(8'h38, {5'd0, nc, sel}); wr(8'h3D, {7'd0, ien}); wr(8'h3C, 8'h07);
      load(cm); wr(8'h30, 8'($urandom % 2));
      bm = 1; dm = 0; em = 0;
      for (int c = 0; c < 80 && bm; c++) begin
        logic a, r, w, e;
        a = 1'($urandom); r = 1'($urandom); w = 1'($urandom);
        e = (($urandom % 16) == 0) || (c == 70);
        pulse(a, r, w, e);
        if (e) begin bm = 0; em = 1; end
        else if (!nc && sel_hit(sel, a, r, w)) begin
          cm = cm - 1;
          if (cm == 0) begin bm = 0; dm = 1; end
        end
        chk("R5 random busy", busy, bm);
      end
      rdcnt(v); chk("R4 random count", v, cm);
      rd(8'h3C, b); chk("R7 random status", b[2:0], {1'b0, em, dm});
      chk("R11 random irq", irq, dm & ien);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule